// File: doc/BRIEF.md
# Radix-4 Modular Division Engine

This block computes the modular quotient c = b · a⁻¹ mod p for an odd prime modulus p. The caller does not need to compute an inverse first and then multiply. The engine runs a binary extended-Euclidean reduction that can remove two trailing zero bits in a single step. It uses only shifts, additions, subtractions and magnitude comparisons, so it needs no multiplier. It is intended to sit beside a point-arithmetic unit, for example to turn projective coordinates into affine ones.

A caller presents a, b and p, and pulses `start_i` while the engine is idle. The engine then carries out one reduction step per clock. It holds two working magnitudes, u (starting at a) and v (starting at p). It also holds two residue companions, x1 (starting at b) and x2 (starting at 0). The step taken depends on the low two bits of u and v. When v reaches zero, x1 holds the quotient. The engine then raises `done_o` for one cycle and keeps the result on `c_o`. The operand width is a parameter, 256 bits by default. Operands narrower than p are handled by the same datapath.

The caller must guarantee that p is an odd prime, that 1 ≤ a < p and that 0 ≤ b < p. Neither condition is checked.

Top module: `modinv_r4_engine`

## Requirements
- R1: After a synchronous active-low reset, including a reset applied in the middle of a computation, `busy_o` and `done_o` are both 0.
- R2: For an odd prime p, 1 ≤ a < p and 0 ≤ b < p, the value on `c_o` during the `done_o` cycle equals b · a⁻¹ mod p.
- R3: The special operands give the following results: a = 1 gives b; b = 1 gives the modular inverse of a; b = 0 gives 0; a = p − 1 gives (p − b) mod p.
- R4: A `start_i` sampled high at a rising edge while idle is accepted. `busy_o` is 1 from the next cycle through the cycle in which `done_o` is 1. `done_o` is 1 for exactly one cycle, after which both outputs return to 0.
- R5: A `start_i` that arrives while `busy_o` is 1 is ignored. The running computation keeps its operands and returns its own result, and no second `done_o` pulse follows.
- R6: After `done_o`, `c_o` holds the result until the next accepted start, whatever happens on `a_i`, `b_i` and `p_i`.
- R7: Each step first checks u ≡ 0 (mod 4), then v ≡ 0 (mod 4), then equal low two bits, then u ending in binary 10, then v ending in binary 10. Otherwise both are odd with different low bits. The working magnitudes stay within u < p and v ≤ p, and both residues stay fully reduced below p in every step.
- R8: Every step strictly reduces u + v. `done_o` arrives no more than 2·W + 3 clock cycles after the accepting edge.
- R9: The engine is exact at the full 256-bit width for 256-bit prime moduli.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Request a new division; sampled only while idle |
| a_i | input | W | Divisor a, 1 ≤ a < p |
| b_i | input | W | Dividend b, 0 ≤ b < p |
| p_i | input | W | Odd prime modulus |
| busy_o | output | 1 | Computation in progress, including the done cycle |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| c_o | output | W | Quotient b · a⁻¹ mod p; valid with done_o and held afterwards |

## Verification
The assertions check on every cycle that the magnitude and residue registers stay inside their ranges and that u + v shrinks on every step. They also check that the step count stays within its bound, that done is a single-cycle pulse inside the busy window, and that the captured modulus does not move while busy. Whether the quotient is numerically correct can only be shown by the bench. It compares results against an independent reference built from exponentiation by p − 2, using several small primes and two 256-bit primes. Special operands, starts that arrive mid-run, reset in the middle of a run, and result hold after completion are likewise shown only by the bench's scenarios.

// File: rtl/modinv_pkg.sv
// Package: shared types for the radix-4 modular division engine.
// Assumes nothing beyond a single clock domain.
package modinv_pkg;

    // Controller states: idle/load, one reduction step per cycle, result pulse.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_OUT  = 2'd2
    } minv_state_t;

endpackage

// File: rtl/modp_sub.sv
// Module: modp_sub
// Computes (x - y) mod p in one combinational pass.
// Assumes x < p and y < p, so a single conditional add of p suffices.
module modp_sub #(
    parameter int W = 256
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] p_i,
    output logic [W-1:0] d_o
);

    logic [W:0] raw;

    // Raw difference with one borrow bit on top.
    assign raw = {1'b0, x_i} - {1'b0, y_i};

    // On borrow, the low W bits equal x - y + 2^W; adding p wraps to x - y + p.
    assign d_o = raw[W] ? (raw[W-1:0] + p_i) : raw[W-1:0];

endmodule

// File: rtl/modp_scale.sv
// Module: modp_scale
// Divides a residue by 2 (SHIFT = 1) or by 4 (SHIFT = 2) modulo an odd p.
// Adds the multiple of p that clears the low SHIFT bits, then shifts right.
// Assumes x < p and p odd; the result is again below p.
module modp_scale #(
    parameter int W     = 256,
    parameter int SHIFT = 2
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] p_i,
    output logic [W-1:0] y_o
);

    localparam int XW = W + SHIFT;

    generate
        if (SHIFT == 1) begin : g_half
            logic [XW-1:0] ext;
            logic          unused_lsb;

            // Odd values get one p added so the sum is even.
            assign ext        = {1'b0, x_i} + (x_i[0] ? {1'b0, p_i} : {XW{1'b0}});
            assign y_o        = ext[XW-1:1];
            assign unused_lsb = ext[0];
        end else begin : g_quarter
            logic [1:0]    prod_lo;
            logic [1:0]    k;
            logic [XW-1:0] pw;
            logic [XW-1:0] mult;
            logic [XW-1:0] ext;
            logic          unused_lsbs;

            // p is its own inverse mod 4, so k = -x*p mod 4 clears two bits.
            assign prod_lo = x_i[1:0] * p_i[1:0];
            assign k       = 2'd0 - prod_lo;
            assign pw      = {2'b00, p_i};

            // Select 0, p, 2p or 3p.
            always_comb begin
                case (k)
                    2'd0:    mult = '0;
                    2'd1:    mult = pw;
                    2'd2:    mult = pw << 1;
                    default: mult = pw + (pw << 1);
                endcase
            end

            assign ext         = {2'b00, x_i} + mult;
            assign y_o         = ext[XW-1:2];
            assign unused_lsbs = ^ext[1:0];
        end
    endgenerate

endmodule

// File: rtl/r4_step_unit.sv
// Module: r4_step_unit
// One reduction step of the radix-4 binary Euclidean division.
// Exactly one (magnitude, residue) pair changes per step; the other passes through.
// Assumes u < p, v <= p, x1 < p, x2 < p, v != 0 and gcd(u, v) = 1.
module r4_step_unit #(
    parameter int W = 256
) (
    input  logic [W-1:0] u_i,
    input  logic [W-1:0] v_i,
    input  logic [W-1:0] x1_i,
    input  logic [W-1:0] x2_i,
    input  logic [W-1:0] p_i,
    output logic [W-1:0] u_o,
    output logic [W-1:0] v_o,
    output logic [W-1:0] x1_o,
    output logic [W-1:0] x2_o
);

    logic [W-1:0] d12, d21;
    logic         upd_u, use_diff, quarter;
    logic [W-1:0] mag_src, res_src;
    logic [W-1:0] mag_new, res_new;
    logic [W-1:0] res_half, res_quarter;

    // Residue differences for both subtraction directions.
    modp_sub #(.W(W)) u_sub12 (.x_i(x1_i), .y_i(x2_i), .p_i(p_i), .d_o(d12));
    modp_sub #(.W(W)) u_sub21 (.x_i(x2_i), .y_i(x1_i), .p_i(p_i), .d_o(d21));

    // Case selection on the low two bits, in fixed priority order.
    always_comb begin
        upd_u    = 1'b0;
        use_diff = 1'b0;
        quarter  = 1'b0;
        if (u_i[1:0] == 2'b00) begin
            upd_u   = 1'b1;
            quarter = 1'b1;
        end else if (v_i[1:0] == 2'b00) begin
            quarter = 1'b1;
        end else if (u_i[1:0] == v_i[1:0]) begin
            upd_u    = (u_i > v_i);
            use_diff = 1'b1;
            quarter  = 1'b1;
        end else if (u_i[1:0] == 2'b10) begin
            upd_u = 1'b1;
        end else if (v_i[1:0] == 2'b10) begin
            upd_u = 1'b0;
        end else begin
            upd_u    = (u_i > v_i);
            use_diff = 1'b1;
        end
    end

    // Operand selection for the pair being updated.
    always_comb begin
        if (upd_u) begin
            mag_src = use_diff ? (u_i - v_i) : u_i;
            res_src = use_diff ? d12 : x1_i;
        end else begin
            mag_src = use_diff ? (v_i - u_i) : v_i;
            res_src = use_diff ? d21 : x2_i;
        end
    end

    // Modular halving and quartering of the selected residue.
    modp_scale #(.W(W), .SHIFT(1)) u_half    (.x_i(res_src), .p_i(p_i), .y_o(res_half));
    modp_scale #(.W(W), .SHIFT(2)) u_quarter (.x_i(res_src), .p_i(p_i), .y_o(res_quarter));

    assign mag_new = quarter ? (mag_src >> 2) : (mag_src >> 1);
    assign res_new = quarter ? res_quarter : res_half;

    // Route results back to the updated pair.
    assign u_o  = upd_u ? mag_new : u_i;
    assign v_o  = upd_u ? v_i : mag_new;
    assign x1_o = upd_u ? res_new : x1_i;
    assign x2_o = upd_u ? x2_i : res_new;

endmodule

// File: rtl/modinv_r4_engine.sv
// Module: modinv_r4_engine (top)
// Sequential engine returning c = b * a^-1 mod p, one reduction step per clock.
// Assumes p odd prime, 1 <= a < p, 0 <= b < p; nothing is checked.
// start_i is accepted only in the idle state; operands are captured at that edge.
module modinv_r4_engine
    import modinv_pkg::*;
#(
    parameter int W = 256
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] p_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] c_o
);

    minv_state_t  state_q;
    logic [W-1:0] u_q, v_q, x1_q, x2_q, p_q;
    logic [W-1:0] u_n, v_n, x1_n, x2_n;

    // Combinational reduction step on the current registers.
    r4_step_unit #(.W(W)) u_step (
        .u_i (u_q),
        .v_i (v_q),
        .x1_i(x1_q),
        .x2_i(x2_q),
        .p_i (p_q),
        .u_o (u_n),
        .v_o (v_n),
        .x1_o(x1_n),
        .x2_o(x2_n)
    );

    // Controller and working registers: load, step until v is zero, then pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            u_q     <= '0;
            v_q     <= '0;
            x1_q    <= '0;
            x2_q    <= '0;
            p_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        u_q     <= a_i;
                        v_q     <= p_i;
                        x1_q    <= b_i;
                        x2_q    <= '0;
                        p_q     <= p_i;
                        state_q <= ST_ITER;
                    end
                end
                ST_ITER: begin
                    if (v_q == '0) begin
                        state_q <= ST_OUT;
                    end else begin
                        u_q  <= u_n;
                        v_q  <= v_n;
                        x1_q <= x1_n;
                        x2_q <= x2_n;
                    end
                end
                ST_OUT:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_OUT);
    assign c_o    = x1_q;

endmodule

// File: rtl/modinv_r4_chk.sv
// Module: modinv_r4_chk
// Property checker bound to modinv_r4_engine; observes only, drives nothing.
module modinv_r4_chk
    import modinv_pkg::*;
#(
    parameter int W = 256
) (
    input logic         clk,
    input logic         rst_n,
    input minv_state_t  state_q,
    input logic [W-1:0] u_q,
    input logic [W-1:0] v_q,
    input logic [W-1:0] x1_q,
    input logic [W-1:0] x2_q,
    input logic [W-1:0] p_q,
    input logic         busy_o,
    input logic         done_o
);

    localparam int unsigned STEP_LIMIT = 2 * W + 2;

    int unsigned  iter_cnt;
    logic [W:0]   uv_sum;

    // Count consecutive cycles spent in the stepping state.
    always_ff @(posedge clk) begin
        if (!rst_n)                  iter_cnt <= 0;
        else if (state_q == ST_ITER) iter_cnt <= iter_cnt + 1;
        else                         iter_cnt <= 0;
    end

    assign uv_sum = {1'b0, u_q} + {1'b0, v_q};

    AST_UV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER) |-> (u_q < p_q && v_q <= p_q)); // R7

    AST_X_REDUCED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER) |-> (x1_q < p_q && x2_q < p_q)); // R7

    AST_SUM_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER && v_q != '0) |=> (uv_sum < $past(uv_sum))); // R8

    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        iter_cnt <= STEP_LIMIT); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R4

    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o); // R4

    AST_MOD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(p_q)); // R5

endmodule

bind modinv_r4_engine modinv_r4_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .state_q(state_q),
    .u_q    (u_q),
    .v_q    (v_q),
    .x1_q   (x1_q),
    .x2_q   (x2_q),
    .p_q    (p_q),
    .busy_o (busy_o),
    .done_o (done_o)
);

// File: tb/tb_modinv_r4_engine.sv
`timescale 1ns/1ps
// Directed bench for modinv_r4_engine; reference via exponentiation by p - 2.
module tb_modinv_r4_engine;

    localparam int W = 256;
    localparam logic [W-1:0] P_NIST =
        256'hFFFFFFFF00000001000000000000000000000000FFFFFFFFFFFFFFFFFFFFFFFF;
    localparam logic [W-1:0] P_EDW =
        256'h7FFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFED;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i;
    logic [W-1:0] a_i, b_i, p_i;
    logic         busy_o, done_o;
    logic [W-1:0] c_o;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    modinv_r4_engine #(.W(W)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .a_i    (a_i),
        .b_i    (b_i),
        .p_i    (p_i),
        .busy_o (busy_o),
        .done_o (done_o),
        .c_o    (c_o)
    );

    // Record one comparison.
    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mulmod(input logic [W-1:0] x, input logic [W-1:0] y,
                                            input logic [W-1:0] m);
        logic [2*W-1:0] t;
        t = ({{W{1'b0}}, x} * {{W{1'b0}}, y}) % {{W{1'b0}}, m};
        return t[W-1:0];
    endfunction

    function automatic logic [W-1:0] powmod(input logic [W-1:0] base, input logic [W-1:0] e,
                                            input logic [W-1:0] m);
        logic [W-1:0] r, bb;
        r  = 1;
        bb = base % m;
        for (int i = 0; i < W; i++) begin
            if (e[i]) r = mulmod(r, bb, m);
            bb = mulmod(bb, bb, m);
        end
        return r;
    endfunction

    function automatic logic [W-1:0] ref_div(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic [W-1:0] p);
        return mulmod(powmod(a, p - 2, p), b, p);
    endfunction

    function automatic logic [W-1:0] rand_wide();
        logic [W-1:0] r;
        for (int i = 0; i < W / 32; i++) r[i*32 +: 32] = $urandom();
        return r;
    endfunction

    // Launch one division, wait for done, report latency and busy behaviour.
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] p,
                          output logic [W-1:0] res, output int lat, output bit busy_ok);
        @(negedge clk);
        a_i = a; b_i = b; p_i = p; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat     = 1;
        busy_ok = busy_o;
        while (!done_o && lat < 4 * W) begin
            @(negedge clk);
            lat++;
            if (!done_o && !busy_o) busy_ok = 1'b0;
        end
        if (!done_o) begin
            n_checks++;
            n_errors++;
            $display("FAIL R8: actual no done after %0d cycles expected done", lat);
        end
        if (!busy_o) busy_ok = 1'b0;
        res = c_o;
    endtask

    // Run and check result, range and latency for one operand set.
    task automatic exercise(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic [W-1:0] p);
        logic [W-1:0] res;
        int           lat;
        bit           bok;
        run_op(a, b, p, res, lat, bok);
        check(req, res, ref_div(a, b, p));
        check("R7 result below p", W'(res < p), W'(1));
        check("R8 latency bound", W'(lat <= 2 * W + 3), W'(1));
        check("R4 busy through run", W'(bok), W'(1));
    endtask

    // R1: reset values, both initial and mid-run.
    task automatic t_reset();
        logic [W-1:0] res;
        int           lat;
        bit           bok;
        rst_n = 1'b0; start_i = 1'b0; a_i = '0; b_i = '0; p_i = '0;
        repeat (4) @(negedge clk);
        check("R1 busy in reset", W'(busy_o), W'(0));
        check("R1 done in reset", W'(done_o), W'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", W'(busy_o), W'(0));
        @(negedge clk);
        a_i = 5; b_i = 9; p_i = P_NIST; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 busy after mid-run reset", W'(busy_o), W'(0));
        check("R1 done after mid-run reset", W'(done_o), W'(0));
        rst_n = 1'b1;
        @(negedge clk);
        run_op(3, 4, 7, res, lat, bok);
        check("R1 engine usable after reset", res, ref_div(3, 4, 7));
    endtask

    // R2: random operands over several small primes.
    task automatic t_small_primes();
        logic [W-1:0] primes [6];
        primes = '{W'(3), W'(7), W'(13), W'(251), W'(65521), W'(32'h7FFFFFFF)};
        foreach (primes[i]) begin
            for (int k = 0; k < 4; k++) begin
                logic [W-1:0] a, b;
                a = (W'($urandom()) % (primes[i] - 1)) + 1;
                b = W'($urandom()) % primes[i];
                exercise("R2 small prime quotient", a, b, primes[i]);
            end
        end
    endtask

    // R3: special operand values.
    task automatic t_specials();
        logic [W-1:0] res;
        int           lat;
        bit           bok;
        run_op(1, 200, 251, res, lat, bok);
        check("R3 a=1 gives b", res, W'(200));
        run_op(17, 0, 251, res, lat, bok);
        check("R3 b=0 gives 0", res, W'(0));
        run_op(250, 3, 251, res, lat, bok);
        check("R3 a=p-1 gives p-b", res, W'(248));
        run_op(3, 1, 7, res, lat, bok);
        check("R3 b=1 gives inverse", res, W'(5));
        run_op(P_NIST - 1, 1, P_NIST, res, lat, bok);
        check("R3 full-width a=p-1 b=1", res, P_NIST - 1);
        run_op(1, P_NIST - 2, P_NIST, res, lat, bok);
        check("R3 full-width a=1", res, P_NIST - 2);
    endtask

    // R4: handshake shape around the done pulse.
    task automatic t_handshake();
        logic [W-1:0] res;
        int           lat;
        bit           bok;
        run_op(rand_wide() % (P_NIST - 1) + 1, rand_wide() % P_NIST, P_NIST, res, lat, bok);
        check("R4 done seen", W'(done_o), W'(1));
        check("R4 busy during done", W'(busy_o), W'(1));
        @(negedge clk);
        check("R4 done one cycle", W'(done_o), W'(0));
        check("R4 busy drops", W'(busy_o), W'(0));
    endtask

    // R5: start pulses while busy are ignored.
    task automatic t_start_ignored();
        logic [W-1:0] a, b;
        int           guard;
        a = rand_wide() % (P_NIST - 1) + 1;
        b = rand_wide() % P_NIST;
        @(negedge clk);
        a_i = a; b_i = b; p_i = P_NIST; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (2) @(negedge clk);
        a_i = 7; b_i = 2; p_i = 11; start_i = 1'b1;
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        guard = 0;
        while (!done_o && guard < 4 * W) begin
            @(negedge clk);
            guard++;
        end
        check("R5 result of original operands", c_o, ref_div(a, b, P_NIST));
        repeat (3) @(negedge clk);
        check("R5 no second done", W'(done_o), W'(0));
        check("R5 no second run", W'(busy_o), W'(0));
    endtask

    // R6: result held after completion while inputs change.
    task automatic t_hold();
        logic [W-1:0] res;
        int           lat;
        bit           bok;
        run_op(9, 5, 65521, res, lat, bok);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            a_i = rand_wide(); b_i = rand_wide(); p_i = rand_wide();
        end
        @(negedge clk);
        check("R6 result held", c_o, ref_div(9, 5, 65521));
        check("R6 no spurious done", W'(done_o), W'(0));
    endtask

    // R9: full-width random operands on two 256-bit primes.
    task automatic t_full_width();
        for (int k = 0; k < 6; k++) begin
            logic [W-1:0] p, a, b;
            p = (k % 2 == 0) ? P_NIST : P_EDW;
            a = rand_wide() % (p - 1) + 1;
            b = rand_wide() % p;
            exercise("R9 full-width quotient", a, b, p);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 8);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_small_primes();
        t_specials();
        t_handshake();
        t_start_ignored();
        t_hold();
        t_full_width();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule